// File: doc/BRIEF.md
# Byte-Wide SPI Master with Packed Mode Control

This block moves one byte at a time over a four-wire serial peripheral bus. Its clock rate, clock idle level, sampling phase and target device all come from one 8-bit control word. A one-cycle start request loads a byte. The block then generates the serial clock and shifts the byte out most-significant bit first, while it captures the same number of bits from the peripheral. It returns the captured byte together with a one-cycle completion pulse.

Eight active-low select lines are provided, and the control word picks exactly one of them. A per-byte "keep select" flag leaves the chosen line low after the byte ends. Command, address and data bytes can then run back to back inside one select frame. When the flag is clear, each byte is framed separately. The control word is sampled only while the block is idle. A transfer therefore keeps the clock rate, phase and target it started with.

Top module: `spim_engine`

## Requirements
- R1: The control word is split as follows: bits 7:5 are the select index, bit 4 is the clock polarity, bit 3 is the clock phase and bits 2:0 are the divider code. The values in force are those present on the cycle a start is accepted.
- R2: With divider code n, each half period of the serial clock lasts 2^(n+1) system cycles, so the full period is 2^(n+2) cycles. The first edge comes one half period after the select line falls.
- R3: Outside a transfer, the serial clock rests at the polarity bit of the control word: low for 0, high for 1. It follows that bit one cycle later while idle. The first edge of a byte moves away from this level.
- R4: Bits go out MSB first. With phase 0, bit 7 is on the data output from the moment the select line falls, the output changes on edges 2, 4 … 14, and input is sampled on edges 1, 3 … 15. With phase 1, the output changes on edges 1, 3 … 15 and input is sampled on edges 2, 4 … 16.
- R5: Exactly the select line whose number equals the index goes low, and every other line stays high.
- R6: Every byte has exactly 16 clock edges and is full duplex. The returned byte holds the eight input samples, first sample in bit 7.
- R7: With keep-select clear, the select line rises one half period after edge 16, which is 1 + 17·2^(n+1) cycles after the start cycle. With keep-select set, the line stays low and the next byte continues the frame.
- R8: The completion pulse lasts one cycle. The returned byte is valid on that cycle and the busy output is already low then.
- R9: Changes to the control word during a transfer have no effect, and a start request while busy is ignored.
- R10: After reset, all select lines are high and the completion pulse and busy output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 8 | Packed control word (index, polarity, phase, divider) |
| start | input | 1 | One-cycle request to send a byte |
| tx_byte | input | 8 | Byte to send, taken with start |
| hold_sel | input | 1 | Keep the select line low after this byte |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| ss_n | output | 8 | Active-low select lines |
| rx_byte | output | 8 | Byte captured during the last transfer |
| done | output | 1 | One-cycle pulse at the end of each byte |
| busy | output | 1 | High while a byte is in progress |

## Verification
Two things can land on the same clock cycle. One is a fresh start request or a rewrite of the control word. The other is a transfer already under way, whose edge counter and divider may be on that very cycle. The bench provokes this by pulsing start with an inverted byte and inverting the control word a few cycles into a transfer. It then judges the result at the ports. The received bytes on both sides must still match the original pair. The edge count must still be 16, every half period must keep its original length, and the completion pulse must arrive on exactly the cycle the original divider predicts. It also checks that the select line rises on the same cycle as the completion pulse.

// File: rtl/spim_pkg.sv
// Shared types for the byte-wide SPI master.
// Assumes the control word layout is fixed at 8 bits: the field order is
// decoded by the engine and must not be rearranged.
package spim_pkg;

    localparam int IDX_W  = 3;              // select index field width
    localparam int CODE_W = 3;              // divider code field width
    localparam int CFG_W  = IDX_W + 2 + CODE_W;

    // Packed control word, most significant field first.
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              cpol;
        logic              cpha;
        logic [CODE_W-1:0] div;
    } spim_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } spim_state_t;

endpackage

// File: rtl/spim_divider.sv
// Half-period timer for the serial clock.
// While run is high it emits a one-cycle tick every 2^(code+1) cycles.
// Assumes code is held steady while run is high; counter restarts when run drops.
module spim_divider #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = 1 << CODE_W;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic [CODE_W-1:0] shamt;

    // Terminal count is 2^(code+1)-1, built by shifting an all-ones word.
    always_comb begin
        shamt = CODE_W'(CNT_W - 1) - code;
        last  = {CNT_W{1'b1}} >> shamt;
    end

    // Free-running count inside a transfer, wraps at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == last);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/spim_shift.sv
// Transmit and receive shift registers, MSB first.
// On load the transmit byte is taken; with first_out the MSB is put on the
// output at once. drive advances the output bit, sample captures the input.
// Assumes drive and sample never coincide.
module spim_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              first_out,
    input  logic              drive,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx
);
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              mosi_q;

    // Outgoing path: preload, then move one bit per drive strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            tx_sh <= first_out ? (data_in << 1) : data_in;
            if (first_out) begin
                mosi_q <= data_in[DATA_W-1];
            end
        end else if (drive) begin
            mosi_q <= tx_sh[DATA_W-1];
            tx_sh  <= tx_sh << 1;
        end
    end

    // Incoming path: clear on load, shift in one bit per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_sh <= '0;
        end else if (sample) begin
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end
    end

    assign mosi = mosi_q;
    assign rx   = rx_sh;

    AST_DRV_SMP_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive && sample)); // R4

endmodule

// File: rtl/spim_select.sv
// Active-low one-hot select lines.
// grab drives the indexed line low and all others high; release_sel returns
// every line high. grab takes priority if both occur.
module spim_select #(
    parameter int NUM_SEL = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       grab,
    input  logic [$clog2(NUM_SEL)-1:0] idx,
    input  logic                       release_sel,
    output logic [NUM_SEL-1:0]         ss_n
);
    localparam int IW = $clog2(NUM_SEL);

    logic [NUM_SEL-1:0] ss_q;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
        // One register per line: low only when picked by the index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ss_q[i] <= 1'b1;
            end else if (grab) begin
                ss_q[i] <= (idx != IW'(i));
            end else if (release_sel) begin
                ss_q[i] <= 1'b1;
            end
        end
    end

    assign ss_n = ss_q;

    AST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n)); // R5
    AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (release_sel && !grab) |=> (&ss_n)); // R7

endmodule

// File: rtl/spim_engine.sv
// Byte-wide SPI master, top level.
// Takes a packed control word while idle, runs 16 clock edges per byte,
// returns the captured byte with a one-cycle done pulse, and releases the
// select line one half period after the last edge unless asked to keep it.
// Assumes start is a single-cycle request; requests while busy are dropped.
module spim_engine
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic                  start,
    input  logic [DATA_W-1:0]     tx_byte,
    input  logic                  hold_sel,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic [(1<<IDX_W)-1:0] ss_n,
    output logic [DATA_W-1:0]     rx_byte,
    output logic                  done,
    output logic                  busy
);
    localparam int NUM_SEL = 1 << IDX_W;
    localparam int EDGES   = 2 * DATA_W;
    localparam int EDGE_W  = $clog2(EDGES + 1);

    spim_cfg_t         cfg_in;
    spim_state_t       state;
    logic              cpol_q;
    logic              cpha_q;
    logic [CODE_W-1:0] div_q;
    logic              hold_q;
    logic [EDGE_W-1:0] edges;
    logic [EDGE_W-1:0] nxt;
    logic              sclk_q;
    logic              done_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_sh;
    logic              tick;
    logic              accept;
    logic              edge_tick;
    logic              odd_edge;
    logic              drive;
    logic              sample;
    logic              finish;

    // Decode the incoming word and the per-edge strobes.
    always_comb begin
        cfg_in    = spim_cfg_t'(cfg_word);
        accept    = start && (state == ST_IDLE);
        edge_tick = tick && (state == ST_SHIFT);
        nxt       = edges + 1'b1;
        odd_edge  = ~edges[0];
        drive     = edge_tick && (cpha_q ? odd_edge
                                         : (!odd_edge && nxt != EDGE_W'(EDGES)));
        sample    = edge_tick && (cpha_q ? !odd_edge : odd_edge);
        finish    = tick && (state == ST_TAIL);
    end

    // Sequencer: idle tracking, edge generation, tail half period, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            div_q  <= '0;
            hold_q <= 1'b0;
            edges  <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cpol_q <= cfg_in.cpol;
                    cpha_q <= cfg_in.cpha;
                    div_q  <= cfg_in.div;
                    sclk_q <= cfg_in.cpol;
                    if (accept) begin
                        state  <= ST_SHIFT;
                        hold_q <= hold_sel;
                        edges  <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        edges  <= nxt;
                        if (nxt == EDGE_W'(EDGES)) begin
                            state <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result register: captured byte presented with the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (finish) begin
            rx_q <= rx_sh;
        end
    end

    spim_divider #(.CODE_W(CODE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .code  (div_q),
        .tick  (tick)
    );

    spim_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .data_in   (tx_byte),
        .first_out (!cfg_in.cpha),
        .drive     (drive),
        .sample    (sample),
        .miso      (miso),
        .mosi      (mosi),
        .rx        (rx_sh)
    );

    spim_select #(.NUM_SEL(NUM_SEL)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .grab        (accept),
        .idx         (cfg_in.idx),
        .release_sel (finish && !hold_q),
        .ss_n        (ss_n)
    );

    assign sclk    = sclk_q;
    assign done    = done_q;
    assign busy    = (state != ST_IDLE);
    assign rx_byte = rx_q;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cpha_q) && $stable(div_q))); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sclk == cpol_q)); // R3

endmodule

// File: tb/sim_spim_engine.sv
// Self-checking bench: directed corner cases plus seeded random transfers
// against a behavioural peripheral model driven at the falling clock edge.
module sim_spim_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_word = 8'h00;
    logic       start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       hold_sel = 1'b0;
    logic       miso = 1'b0;
    logic       sclk, mosi, done, busy;
    logic [7:0] ss_n, rx_byte;

    always #10 clk = ~clk;

    spim_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .start(start),
        .tx_byte(tx_byte), .hold_sel(hold_sel), .miso(miso), .sclk(sclk),
        .mosi(mosi), .ss_n(ss_n), .rx_byte(rx_byte), .done(done), .busy(busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit timed_out = 1'b0;

    // Peripheral model state.
    int         edge_cnt = 0;
    int         exp_h = 2;
    int         prev_t = 0;
    bit         bad_int = 1'b0;
    bit         first_bad = 1'b0;
    logic [7:0] slave_sh = 8'h00;
    logic [7:0] slave_rx = 8'h00;
    logic       cur_cpol = 1'b0;
    logic       cur_cpha = 1'b0;
    logic       prev_sclk = 1'b0;

    // Model: reacts to each serial clock edge seen during a transfer.
    always @(negedge clk) begin
        if (busy === 1'b1 && sclk !== prev_sclk) begin
            edge_cnt = edge_cnt + 1;
            if (cyc - prev_t != exp_h) bad_int = 1'b1;
            prev_t = cyc;
            if (edge_cnt == 1 && sclk !== ~cur_cpol) first_bad = 1'b1;
            if (cur_cpha ? (edge_cnt % 2 == 0) : (edge_cnt % 2 == 1))
                slave_rx = {slave_rx[6:0], mosi};
            if (cur_cpha ? (edge_cnt % 2 == 1) : (edge_cnt % 2 == 0 && edge_cnt < 16)) begin
                miso = slave_sh[7];
                slave_sh = {slave_sh[6:0], 1'b0};
            end
        end
        prev_sclk = sclk;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] sel_pattern(input logic [7:0] cfg);
        return ~(8'd1 << cfg[7:5]);
    endfunction

    function automatic int half_len(input logic [7:0] cfg);
        return 1 << (int'(cfg[2:0]) + 1);
    endfunction

    // One byte: configure, start, optionally disturb, then judge at done.
    task automatic xfer(input logic [7:0] cfg, input logic [7:0] tx, input logic [7:0] stx,
                        input bit hold, input bit disturb);
        int h;
        int t0;
        logic [7:0] pat;
        @(negedge clk);
        cfg_word = cfg;
        repeat (2) @(negedge clk);
        h = half_len(cfg);
        pat = sel_pattern(cfg);
        chk(sclk === cfg[4], "R3 rest level before start", 32'(sclk), 32'(cfg[4]));
        cur_cpol = cfg[4];
        cur_cpha = cfg[3];
        exp_h = h;
        edge_cnt = 0;
        bad_int = 1'b0;
        first_bad = 1'b0;
        slave_rx = 8'h00;
        if (!cfg[3]) begin
            miso = stx[7];
            slave_sh = {stx[6:0], 1'b0};
        end else begin
            slave_sh = stx;
        end
        t0 = cyc;
        prev_t = t0 + 1;
        start = 1'b1;
        tx_byte = tx;
        hold_sel = hold;
        @(negedge clk);
        start = 1'b0;
        chk(ss_n === pat, "R1 R5 select pattern", 32'(ss_n), 32'(pat));
        chk(busy === 1'b1, "R8 busy after start", 32'(busy), 32'd1);
        if (disturb) begin
            repeat (3) @(negedge clk);
            cfg_word = ~cfg;
            start = 1'b1;
            tx_byte = ~tx;
            hold_sel = ~hold;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(rx_byte === stx, disturb ? "R9 R6 rx byte after disturb" : "R6 rx byte", 32'(rx_byte), 32'(stx));
        chk(slave_rx === tx, disturb ? "R9 R4 peripheral got byte" : "R4 peripheral got byte", 32'(slave_rx), 32'(tx));
        chk(edge_cnt == 16, "R6 edge count", 32'(edge_cnt), 32'd16);
        chk(!bad_int, "R2 half period length", 32'(bad_int), 32'd0);
        chk(!first_bad, "R3 first edge direction", 32'(first_bad), 32'd0);
        chk(cyc - t0 == 1 + 17 * h, "R7 byte duration", 32'(cyc - t0), 32'(1 + 17 * h));
        chk(ss_n === (hold ? pat : 8'hFF), "R7 select after byte", 32'(ss_n), 32'(hold ? pat : 8'hFF));
        chk(busy === 1'b0, "R8 idle at done", 32'(busy), 32'd0);
        if (disturb) cfg_word = cfg;
        @(negedge clk);
        chk(done === 1'b0, "R8 done lasts one cycle", 32'(done), 32'd0);
    endtask

    task automatic run_all();
        logic [7:0] c;
        repeat (3) @(negedge clk);
        chk(ss_n === 8'hFF, "R10 selects high in reset", 32'(ss_n), 32'hFF);
        chk(done === 1'b0, "R10 done low in reset", 32'(done), 32'd0);
        chk(busy === 1'b0, "R10 busy low in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        // Directed: all four modes at the fastest rate.
        xfer({3'd0, 1'b0, 1'b0, 3'd0}, 8'hA5, 8'h3C, 1'b0, 1'b0);
        xfer({3'd7, 1'b0, 1'b1, 3'd0}, 8'h81, 8'h7E, 1'b0, 1'b0);
        xfer({3'd3, 1'b1, 1'b0, 3'd0}, 8'hF0, 8'h0F, 1'b0, 1'b0);
        xfer({3'd5, 1'b1, 1'b1, 3'd0}, 8'h01, 8'h80, 1'b0, 1'b0);
        // Slowest divider once.
        xfer({3'd2, 1'b0, 1'b1, 3'd7}, 8'h5A, 8'hC3, 1'b0, 1'b0);
        // Held frame: three bytes with the select kept low, then released.
        xfer({3'd6, 1'b1, 1'b0, 3'd1}, 8'h06, 8'h11, 1'b1, 1'b0);
        xfer({3'd6, 1'b1, 1'b0, 3'd1}, 8'h02, 8'h22, 1'b1, 1'b0);
        xfer({3'd6, 1'b1, 1'b0, 3'd1}, 8'h9C, 8'h33, 1'b0, 1'b0);
        // Disturbed transfer at minimum divider.
        xfer({3'd1, 1'b0, 1'b0, 3'd0}, 8'hC6, 8'h5D, 1'b0, 1'b1);
        // R3: idle level follows polarity bit while idle.
        @(negedge clk);
        cfg_word = 8'b000_1_0_000;
        repeat (2) @(negedge clk);
        chk(sclk === 1'b1, "R3 idle follows polarity high", 32'(sclk), 32'd1);
        cfg_word = 8'b000_0_0_000;
        repeat (2) @(negedge clk);
        chk(sclk === 1'b0, "R3 idle follows polarity low", 32'(sclk), 32'd0);
        // Seeded random transfers.
        for (int i = 0; i < 30; i++) begin
            c = 8'($urandom);
            c[2:0] = 3'($urandom_range(0, 4));
            xfer(c, 8'($urandom), 8'($urandom), 1'b0, ($urandom_range(0, 3) == 0));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule